// File: doc/BRIEF.md
# Option Register with Clock-Loss Watchdog

This block holds one eight-bit system configuration word at a single bus address. It also contains a watchdog that raises a reset request when the bus clock slows down or stops. The bus clock `clk_i` serves two roles: it clocks the register, and it is the clock being watched. The watchdog runs from a free-running reference clock `ref_clk_i`. It brings the bus clock into the reference domain through a synchronizer. It then counts reference ticks since the last rising edge of the bus clock. If that count reaches `TIMEOUT` while monitoring is enabled, `reset_req_o` rises and stays high until `rst_ni` is asserted. A system reset sequencer is expected to act on this request.

The register bits fall into two groups. The open bits are power-up control (bit 7), clock select (bit 6) and monitor enable (bit 3). Software can rewrite them at any time. The guarded bits are interrupt sense (bit 5), startup delay (bit 4), monitor force (bit 2) and the two rate bits (bits 1:0). In normal mode the guarded bits take only the first write after reset, and only if that write falls in the first `WIN_CYCLES` bus cycles. In test mode (`test_mode_i` high) the guarded bits are always writable. The monitor is active when the enable bit or the force bit is set. The force bit can be set, but only a reset clears it.

Top module: `cfg_clk_watch`

## Requirements
- R1: After reset, `rdata_o` reads 8'h10: only bit 4 (startup delay) is 1. `rdata_o` always shows the register contents, and reading it has no effect.
- R2: A write (`wr_en_i` high at a rising edge of `clk_i`) always loads bits 7, 6 and 3 from `wdata_i`, in any mode and at any time.
- R3: In normal mode, the guarded bits 5, 4, 2, 1 and 0 are loaded by a write sampled at bus edges 0 to 63 after reset release. Edge 0 is the first edge after release. From edge 64 onward, writes leave the guarded bits unchanged.
- R4: In normal mode, the first write closes the guarded window. Later writes leave bits 5, 4, 2, 1 and 0 unchanged.
- R5: In test mode, the guarded bits accept any number of writes at any time, and test-mode writes do not close the window.
- R6: Bit 2 (monitor force), once set, reads 1 until `rst_ni` is asserted. A write of 0 never clears it.
- R7: The watchdog is active only when bit 3 or bit 2 is 1. With both bits at 0, a stopped bus clock never raises `reset_req_o`.
- R8: With the watchdog active and the bus clock stopped, `reset_req_o` rises between `TIMEOUT` and `TIMEOUT`+5 reference cycles after the last bus rising edge. A bus clock period of 2*`TIMEOUT` reference cycles also raises it.
- R9: With the watchdog active, a bus clock whose rising edges are at most `TIMEOUT`-4 reference cycles apart never raises `reset_req_o`.
- R10: Once high, `reset_req_o` stays high even if the bus clock restarts. It clears only when `rst_ni` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; this is also the clock being monitored |
| ref_clk_i | input | 1 | Free-running reference clock for the watchdog |
| rst_ni | input | 1 | Asynchronous active-low reset |
| test_mode_i | input | 1 | 1 = special/test mode; guarded bits are always writable |
| wr_en_i | input | 1 | Write strobe for the register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Current register contents |
| reset_req_o | output | 1 | Sticky reset request from the watchdog |

## Verification
If the window counter or the lock latch is wrong, it shows in `rdata_o` on the cycle after the write. A guarded field either takes a value it should have refused or refuses one it should have taken. The bench hits this at the 63/64 boundary, and after a second write both inside and outside test mode. If the watchdog counter or its edge detection is wrong, `reset_req_o` moves outside the `TIMEOUT`..`TIMEOUT`+5 window after the clock stops. A false trip shows up within a few bus periods of a slow clock that should be allowed. An enable path that ignores the force bit shows as no trip at all.

// File: rtl/sysopt_pkg.sv
package sysopt_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned POS_ENA   = 3;  // monitor enable, open
  localparam int unsigned POS_FORCE = 2;  // monitor force, set-only
  localparam logic [REG_W-1:0] RST_VAL   = 8'h10;
  localparam logic [REG_W-1:0] OPEN_MASK = 8'hC8;
  localparam logic [REG_W-1:0] PROT_MASK = 8'h37;
  typedef logic [REG_W-1:0] opt_t;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/opt_reg.sv
module opt_reg
  import sysopt_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic test_mode_i,
  input  logic wr_en_i,
  input  opt_t wdata_i,
  output opt_t q_o,
  output logic locked_o
);
  localparam int unsigned CW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

  logic [CW-1:0] win_q;
  logic          lock_q;
  logic          prot_ok;
  opt_t          q_q, q_d;

  assign prot_ok = test_mode_i | ~lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      if (!lock_q && win_q != LAST) win_q <= win_q + 1'b1;
      if ((wr_en_i && !test_mode_i) || win_q == LAST) lock_q <= 1'b1;
    end
  end

  always_comb begin
    q_d = q_q;
    if (wr_en_i) begin
      q_d = (q_q & ~OPEN_MASK) | (wdata_i & OPEN_MASK);
      if (prot_ok) q_d = (q_d & ~PROT_MASK) | (wdata_i & PROT_MASK);
      q_d[POS_FORCE] = q_q[POS_FORCE] | (prot_ok & wdata_i[POS_FORCE]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q_q <= RST_VAL;
    else         q_q <= q_d;

  assign q_o      = q_q;
  assign locked_o = lock_q;
endmodule

// File: rtl/clk_watch.sv
module clk_watch #(
  parameter int unsigned TIMEOUT     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic mon_clk_i,
  input  logic enable_i,
  output logic en_sync_o,
  output logic req_o
);
  localparam int unsigned CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIM  = CW'(TIMEOUT);
  localparam logic [CW-1:0] TRIP = CW'(TIMEOUT - 1);

  logic ck_s, ck_d, en_s, rise;
  logic [CW-1:0] cnt_q;
  logic req_q;

  bit_sync #(.STAGES(SYNC_STAGES)) u_ck_sync (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .d_i(mon_clk_i), .q_o(ck_s)
  );
  bit_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .d_i(enable_i), .q_o(en_s)
  );

  assign rise = ck_s & ~ck_d;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_d  <= 1'b0;
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      ck_d <= ck_s;
      if (!en_s || rise)  cnt_q <= '0;
      else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
      // sticky until reset
      if (en_s && !rise && cnt_q == TRIP) req_q <= 1'b1;
    end
  end

  assign en_sync_o = en_s;
  assign req_o     = req_q;
endmodule

// File: rtl/cfg_clk_watch.sv
module cfg_clk_watch
  import sysopt_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = 64,
  parameter int unsigned TIMEOUT    = 16
) (
  input  logic       clk_i,
  input  logic       ref_clk_i,
  input  logic       rst_ni,
  input  logic       test_mode_i,
  input  logic       wr_en_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       reset_req_o
);
  opt_t q;
  logic locked;
  logic mon_en;
  logic mon_en_ref;

  opt_reg #(.WIN_CYCLES(WIN_CYCLES)) u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .test_mode_i(test_mode_i),
    .wr_en_i(wr_en_i), .wdata_i(wdata_i), .q_o(q), .locked_o(locked)
  );

  assign mon_en = q[POS_ENA] | q[POS_FORCE];

  clk_watch #(.TIMEOUT(TIMEOUT)) u_watch (
    .ref_clk_i(ref_clk_i), .rst_ni(rst_ni), .mon_clk_i(clk_i),
    .enable_i(mon_en), .en_sync_o(mon_en_ref), .req_o(reset_req_o)
  );

  assign rdata_o = q;
endmodule

// File: rtl/cfg_clk_watch_chk.sv
module cfg_clk_watch_chk
  import sysopt_pkg::*;
(
  input logic       clk_i,
  input logic       ref_clk_i,
  input logic       rst_ni,
  input logic       test_mode_i,
  input logic       wr_en_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       reset_req_o,
  input logic       locked,
  input logic       mon_en_ref
);
  assert_open_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ((rdata_o & OPEN_MASK) == ($past(wdata_i) & OPEN_MASK)));

  assert_guard_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && !test_mode_i) |=>
      ((rdata_o & PROT_MASK) == ($past(rdata_o) & PROT_MASK)));

  assert_first_write_locks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !test_mode_i) |=> locked);

  assert_force_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(rdata_o[POS_FORCE]));

  assert_req_needs_enable_R7: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $rose(reset_req_o) |-> $past(mon_en_ref));

  assert_req_sticky_R10: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    reset_req_o |=> reset_req_o);
endmodule

bind cfg_clk_watch cfg_clk_watch_chk u_chk (
  .clk_i(clk_i), .ref_clk_i(ref_clk_i), .rst_ni(rst_ni),
  .test_mode_i(test_mode_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .reset_req_o(reset_req_o),
  .locked(locked), .mon_en_ref(mon_en_ref)
);

// File: tb/cfg_clk_watch_tb.sv
`timescale 1ns/1ps
module cfg_clk_watch_tb;
  localparam int CLK_PERIOD = 20;
  localparam int REF_PERIOD = 10;
  localparam int TIMEOUT    = 16;
  localparam int WIN        = 64;
  localparam logic [7:0] OPEN = 8'hC8;
  localparam logic [7:0] PROT = 8'h37;

  logic clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
  logic test_mode = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic req;
  int   bus_half = CLK_PERIOD / 2;
  bit   bus_run  = 1'b1;
  int   n_tests = 0, n_fail = 0, wd = 0;

  cfg_clk_watch #(.WIN_CYCLES(WIN), .TIMEOUT(TIMEOUT)) u_dut (
    .clk_i(clk), .ref_clk_i(ref_clk), .rst_ni(rst_n), .test_mode_i(test_mode),
    .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata), .reset_req_o(req)
  );

  initial forever begin #(bus_half); if (bus_run) clk = ~clk; end
  initial begin #2; forever #(REF_PERIOD/2) ref_clk = ~ref_clk; end

  always @(posedge ref_clk) begin
    wd++;
    if (wd > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL R8 watchdog: actual %0d cycles expected < 150000", wd);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [7:0] exp_write(logic [7:0] old, logic [7:0] d, bit guard_ok);
    logic [7:0] r;
    r = (old & ~OPEN) | (d & OPEN);
    if (guard_ok) r = (r & ~PROT) | (d & PROT);
    r[2] = old[2] | (guard_ok & d[2]);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit tm);
    bus_run = 1'b1; bus_half = CLK_PERIOD / 2;
    wr_en = 1'b0; test_mode = tm; rst_n = 1'b0;
    #(5*CLK_PERIOD);
    @(negedge clk); rst_n = 1'b1;   // next posedge is bus edge 0
  endtask

  task automatic write_at(input int n, input logic [7:0] d);
    repeat (n) @(negedge clk);
    wr_en = 1'b1; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic stop_and_measure(output int n);
    @(posedge clk); #1 bus_run = 1'b0;
    n = 0;
    while (!req && n < 10*TIMEOUT) begin @(posedge ref_clk); n++; end
    #1;
  endtask

  initial begin
    int n;
    logic [7:0] e;
    void'($urandom(32'd4711));

    // R1
    do_reset(1'b0);
    chk("R1 reset value", rdata, 8'h10);
    chk("R1 no request after reset", req, 1'b0);

    // R2 R4 R6
    write_at(0, 8'hFF);
    chk("R3 write at edge 0", rdata, 8'hFF);
    wr(8'h00);
    chk("R4/R2/R6 second write", rdata, 8'h37);

    // R3 boundary
    do_reset(1'b0);
    write_at(WIN-1, 8'h2B);
    chk("R3 write at edge 63", rdata, 8'h2B);
    do_reset(1'b0);
    write_at(WIN, 8'h2B);
    chk("R3 write at edge 64 ignored", rdata, 8'h18);

    // R5
    do_reset(1'b1);
    wr(8'hFF); wr(8'h00);
    chk("R5/R6 test mode rewrite", rdata, 8'h04);
    write_at(80, 8'h33);
    chk("R5 test mode late write", rdata, 8'h37);

    // random mix, R2 R3 R4 R5
    for (int i = 0; i < 20; i++) begin
      bit tm;
      int at;
      logic [7:0] d1, d2;
      tm = 1'($urandom % 4 == 0);
      at = int'($urandom % 90);
      d1 = 8'($urandom); d2 = 8'($urandom);
      do_reset(tm);
      write_at(at, d1);
      e = exp_write(8'h10, d1, tm || at < WIN);
      chk("R3 random first write", rdata, e);
      wr(d2);
      e = exp_write(e, d2, tm);
      chk("R4 random second write", rdata, e);
    end

    // R7 disabled
    do_reset(1'b0);
    wr(8'h00);
    repeat (10) @(negedge clk);
    @(posedge clk); #1 bus_run = 1'b0;
    repeat (4*TIMEOUT) @(posedge ref_clk);
    #1 chk("R7 disabled no trip", req, 1'b0);

    // R8 R9 R10 via enable bit
    do_reset(1'b0);
    wr(8'h08);
    repeat (20) @(negedge clk);
    chk("R9 nominal clock no trip", req, 1'b0);
    stop_and_measure(n);
    chk("R8 stop latency in window", (n >= TIMEOUT && n <= TIMEOUT+5), 1'b1);
    if (!(n >= TIMEOUT && n <= TIMEOUT+5)) $display("  measured %0d", n);
    bus_run = 1'b1;
    repeat (20) @(negedge clk);
    chk("R10 request sticky", req, 1'b1);
    do_reset(1'b0);
    chk("R10 cleared by reset", req, 1'b0);

    // R7 force bit alone
    write_at(0, 8'h04);
    repeat (10) @(negedge clk);
    stop_and_measure(n);
    chk("R7 force bit enables", req, 1'b1);

    // R9 slow but legal, then R8 too slow
    do_reset(1'b0);
    wr(8'h08);
    bus_half = (TIMEOUT-4) * REF_PERIOD / 2;
    repeat (30) @(negedge clk);
    chk("R9 slow legal clock", req, 1'b0);
    bus_half = TIMEOUT * REF_PERIOD;
    repeat (6) @(negedge clk);
    chk("R8 too slow clock trips", req, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule